// File: doc/BRIEF.md
# Strobe Handshake FIFO

This block is a first-in first-out buffer, 64 words deep by default and 5 bits wide, with no shared clock at its edge. The writer presents a word and raises a shift-in strobe. The reader takes the word on the data outputs and acknowledges it with a shift-out strobe. Each side has a ready flag that acts as the other half of its handshake. A ready flag drops as soon as its strobe is taken, and it is evaluated again only when that strobe falls. This spaces the transfers on each side without any further protocol.

Internally, one system clock samples both strobes through two-flop synchronizers and finds their edges. The words sit in a dual-port array that a write ring pointer and a read ring pointer address. The oldest stored word falls through to an output register without any read request. The output register changes only after a completed shift-out, so the reader always sees a stable word while its strobe is high. An output enable lets the data outputs share a bus.

Top module: `strobe_fifo`

## Requirements
- R1: While `rstN` is low, and in the first cycles after it is released, `inReady` is 1 and `outReady` is 0. Any stored words are discarded.
- R2: A shift-in is taken only while `inReady` is 1. A strobe given while `inReady` is 0 writes nothing, and its word never appears on the outputs.
- R3: Taking a shift-in drives `inReady` to 0 while `shiftIn` stays high. After `shiftIn` falls, `inReady` returns to 1 if fewer than DEPTH words are stored. With DEPTH words stored, it stays 0.
- R4: The first word written into an empty buffer appears on `dataOut`, and `outReady` goes to 1, with no shift-out given.
- R5: A shift-out is taken only while `outReady` is 1. Taking it drives `outReady` to 0, and `dataOut` keeps the same word while `shiftOut` stays high.
- R6: After `shiftOut` falls, the next stored word is presented and `outReady` returns to 1. Words leave in the order they were written.
- R7: When the last word has been shifted out, `outReady` stays 0 and `dataOut` keeps that last word.
- R8: If `shiftIn` is held high while the buffer is full, the word is written as soon as a shift-out frees a location. The buffer is then full again.
- R9: If `shiftOut` is held high while the buffer is empty, a newly written word is presented. `outReady` goes to 1 for a single clock and then drops.
- R10: With `outEnable` at 0, `dataOut` is high impedance. With `outEnable` at 1, it drives the presented word.
- R11: Writes and reads may overlap freely. Ordering holds, the count of stored words never goes above DEPTH, and the count changes by at most one per clock.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock that samples the strobes |
| rstN | input | 1 | Master reset, active low |
| shiftIn | input | 1 | Write strobe, level sensitive |
| shiftOut | input | 1 | Read acknowledge strobe, level sensitive |
| dataIn | input | WIDTH | Word to be written |
| outEnable | input | 1 | 1 drives `dataOut`, 0 leaves it high impedance |
| inReady | output | 1 | Space is available and a shift-in may be given |
| outReady | output | 1 | A fresh word is presented on `dataOut` |
| dataOut | output | WIDTH | Presented word |

## Verification
The bench builds the buffer with WIDTH=4 and DEPTH=8. With that depth, a test can fill the buffer to capacity, drain it, and hold a strobe against a full or empty buffer within a few hundred cycles. The 4-bit width lets every test draw its data values from the whole code space. The full and empty boundaries and pointer wrap-around are crossed many times, so ring wrap, the full limit and the overlap of write and read completions in one clock are all exercised.

// File: rtl/strobe_fifo_pkg.sv
package strobe_fifo_pkg;

  // Strobes from the control path to the datapath
  typedef struct packed {
    logic wrEn;    // store dataIn at the write pointer
    logic wrAdv;   // write completed: step the write pointer
    logic rdAdv;   // read completed: step the read pointer
    logic load;    // copy the word at the read pointer to the output register
  } fifoStb_t;

endpackage

// File: rtl/strobe_fifo_sync.sv
module strobe_fifo_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rstN,
  input  logic d,
  output logic q
);

  logic [STAGES-1:0] shReg;

  generate
    if (STAGES == 1) begin : g_single
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) shReg <= '0;
        else       shReg <= d;
      end
    end else begin : g_chain
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) shReg <= '0;
        else       shReg <= {shReg[STAGES-2:0], d};
      end
    end
  endgenerate

  assign q = shReg[STAGES-1];

endmodule

// File: rtl/strobe_fifo_ctrl.sv
module strobe_fifo_ctrl
  import strobe_fifo_pkg::*;
#(
  parameter int DEPTH  = 64,
  parameter int SYNC_N = 2,
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             shiftIn,
  input  logic             shiftOut,
  output fifoStb_t         stb,
  output logic             inReady,
  output logic             outReady,
  output logic             rdPending,
  output logic [CNT_W-1:0] occ
);

  logic siLvl, soLvl, siPrev, soPrev;
  logic siFall, soFall;
  logic wrPending;
  logic wrAccept, wrDone, rdAccept, rdDone, loadOut;
  logic [CNT_W-1:0] occNext;
  logic roomNext;

  strobe_fifo_sync #(.STAGES(SYNC_N)) uSiSync (
    .clk(clk), .rstN(rstN), .d(shiftIn), .q(siLvl)
  );

  strobe_fifo_sync #(.STAGES(SYNC_N)) uSoSync (
    .clk(clk), .rstN(rstN), .d(shiftOut), .q(soLvl)
  );

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      siPrev <= 1'b0;
      soPrev <= 1'b0;
    end else begin
      siPrev <= siLvl;
      soPrev <= soLvl;
    end
  end

  assign siFall = siPrev & ~siLvl;
  assign soFall = soPrev & ~soLvl;

  // Write handshake: a high level is taken while ready, completion on fall
  assign wrAccept = siLvl & inReady & ~wrPending;
  assign wrDone   = wrPending & siFall;

  // Read handshake: a high level is taken while ready, completion on fall
  assign rdAccept = soLvl & outReady & ~rdPending;
  assign rdDone   = rdPending & soFall;

  // Present the oldest word when nothing is being shown or consumed
  assign loadOut = ~outReady & ~rdPending & (occ != '0);

  always_comb begin
    occNext  = occ + CNT_W'(wrDone) - CNT_W'(rdDone);
    roomNext = (occNext < CNT_W'(DEPTH));
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      occ       <= '0;
      wrPending <= 1'b0;
      inReady   <= 1'b1;
    end else begin
      occ <= occNext;
      if (wrAccept) begin
        wrPending <= 1'b1;
        inReady   <= 1'b0;
      end else if (!wrPending || wrDone) begin
        wrPending <= 1'b0;
        inReady   <= roomNext;
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rdPending <= 1'b0;
      outReady  <= 1'b0;
    end else begin
      if (rdAccept) begin
        rdPending <= 1'b1;
        outReady  <= 1'b0;
      end else if (rdDone) begin
        rdPending <= 1'b0;
      end else if (loadOut) begin
        outReady  <= 1'b1;
      end
    end
  end

  always_comb begin
    stb.wrEn  = wrAccept;
    stb.wrAdv = wrDone;
    stb.rdAdv = rdDone;
    stb.load  = loadOut;
  end

endmodule

// File: rtl/strobe_fifo_dp.sv
module strobe_fifo_dp
  import strobe_fifo_pkg::*;
#(
  parameter int WIDTH = 5,
  parameter int DEPTH = 64,
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic             clk,
  input  logic             rstN,
  input  fifoStb_t         stb,
  input  logic [WIDTH-1:0] dataIn,
  output logic [WIDTH-1:0] outWord
);

  logic [WIDTH-1:0] mem [DEPTH];
  logic [PTR_W-1:0] wrPtr, rdPtr;

  function automatic logic [PTR_W-1:0] ringStep(input logic [PTR_W-1:0] p);
    if (p == PTR_W'(DEPTH - 1)) return '0;
    return p + 1'b1;
  endfunction

  always_ff @(posedge clk) begin
    if (stb.wrEn) mem[wrPtr] <= dataIn;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      wrPtr <= '0;
      rdPtr <= '0;
    end else begin
      if (stb.wrAdv) wrPtr <= ringStep(wrPtr);
      if (stb.rdAdv) rdPtr <= ringStep(rdPtr);
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)         outWord <= '0;
    else if (stb.load) outWord <= mem[rdPtr];
  end

endmodule

// File: rtl/strobe_fifo.sv
module strobe_fifo
  import strobe_fifo_pkg::*;
#(
  parameter int WIDTH  = 5,
  parameter int DEPTH  = 64,
  parameter int SYNC_N = 2,
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             shiftIn,
  input  logic             shiftOut,
  input  logic [WIDTH-1:0] dataIn,
  input  logic             outEnable,
  output logic             inReady,
  output logic             outReady,
  output logic [WIDTH-1:0] dataOut
);

  fifoStb_t         stb;
  logic             rdPending;
  logic [CNT_W-1:0] occ;
  logic [WIDTH-1:0] outWord;

  strobe_fifo_ctrl #(.DEPTH(DEPTH), .SYNC_N(SYNC_N)) uCtrl (
    .clk(clk), .rstN(rstN), .shiftIn(shiftIn), .shiftOut(shiftOut),
    .stb(stb), .inReady(inReady), .outReady(outReady),
    .rdPending(rdPending), .occ(occ)
  );

  strobe_fifo_dp #(.WIDTH(WIDTH), .DEPTH(DEPTH)) uDp (
    .clk(clk), .rstN(rstN), .stb(stb), .dataIn(dataIn), .outWord(outWord)
  );

  assign dataOut = outEnable ? outWord : {WIDTH{1'bz}};

endmodule

// File: rtl/strobe_fifo_chk.sv
module strobe_fifo_chk #(
  parameter int WIDTH = 5,
  parameter int DEPTH = 64,
  parameter int CNT_W = 7
) (
  input logic             clk,
  input logic             rstN,
  input logic             inReady,
  input logic             outReady,
  input logic             rdPending,
  input logic [CNT_W-1:0] occ,
  input logic [WIDTH-1:0] outWord
);

  // R11
  no_overflow_chk: assert property (@(posedge clk) disable iff (!rstN)
    occ <= CNT_W'(DEPTH));

  // R11
  occ_step_chk: assert property (@(posedge clk) disable iff (!rstN)
    (occ == $past(occ)) || (occ == $past(occ) + 1'b1) || (occ + 1'b1 == $past(occ)));

  // R3
  full_blocks_ir_chk: assert property (@(posedge clk) disable iff (!rstN)
    (occ == CNT_W'(DEPTH)) |-> !inReady);

  // R4
  or_has_word_chk: assert property (@(posedge clk) disable iff (!rstN)
    outReady |-> (occ != '0));

  // R5
  hold_while_so_chk: assert property (@(posedge clk) disable iff (!rstN)
    (rdPending && $past(rdPending)) |-> $stable(outWord));

  // R7
  empty_keeps_word_chk: assert property (@(posedge clk) disable iff (!rstN)
    ((occ == '0) && ($past(occ) == '0)) |-> $stable(outWord));

endmodule

bind strobe_fifo strobe_fifo_chk #(.WIDTH(WIDTH), .DEPTH(DEPTH), .CNT_W(CNT_W)) uChk (
  .clk(clk), .rstN(rstN), .inReady(inReady), .outReady(outReady),
  .rdPending(rdPending), .occ(occ), .outWord(outWord)
);

// File: tb/sim_strobe_fifo.sv
module sim_strobe_fifo;
  localparam int PERIOD = 10;
  localparam int W = 4;
  localparam int D = 8;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic si = 1'b0, so = 1'b0, oe = 1'b1;
  logic [W-1:0] din = '0;
  logic ir, orr;
  logic [W-1:0] dout;

  int errs = 0;
  int checks = 0;
  int orRises = 0;
  logic orPrev = 1'b0;
  logic [W-1:0] model [$];
  logic [W-1:0] lastOut = '0;

  always #(PERIOD/2) clk = ~clk;

  strobe_fifo #(.WIDTH(W), .DEPTH(D)) u0 (
    .clk(clk), .rstN(rstN), .shiftIn(si), .shiftOut(so), .dataIn(din),
    .outEnable(oe), .inReady(ir), .outReady(orr), .dataOut(dout)
  );

  always @(negedge clk) begin
    if (orr && !orPrev) orRises++;
    orPrev <= orr;
  end

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errs++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic waitLvl(input bit wantIr, input bit v, input int lim, output bit ok);
    ok = 1'b0;
    for (int i = 0; i < lim; i++) begin
      if ((wantIr ? ir : orr) == v) begin ok = 1'b1; break; end
      @(negedge clk);
    end
  endtask

  // Writes one word; checks the R3 flag behaviour when irChk is set
  task automatic push(input logic [W-1:0] d, input bit irChk);
    bit ok;
    waitLvl(1'b1, 1'b1, 200, ok);
    chk(ok, "R3 ready before write", ok, 1);
    din = d;
    si = 1'b1;
    model.push_back(d);
    waitLvl(1'b1, 1'b0, 20, ok);
    if (irChk) chk(ok && ir == 1'b0, "R3 ir low after accept", ir, 0);
    cyc(2);
    if (irChk) chk(ir == 1'b0, "R3 ir low while si high", ir, 0);
    si = 1'b0;
    cyc(4);
    if (irChk)
      chk(ir == (model.size() < D), "R3 ir after si fall", ir, int'(model.size() < D));
  endtask

  // Reads one word and compares with the model (R5, R6)
  task automatic pop();
    bit ok;
    logic [W-1:0] exp;
    waitLvl(1'b0, 1'b1, 200, ok);
    exp = model.size() ? model[0] : '0;
    chk(ok && dout == exp, "R6 presented word", dout, exp);
    if (model.size()) void'(model.pop_front());
    so = 1'b1;
    waitLvl(1'b0, 1'b0, 20, ok);
    chk(ok, "R5 or drops on accept", orr, 0);
    cyc(3);
    chk(dout == exp, "R5 word held while so high", dout, exp);
    so = 1'b0;
    lastOut = exp;
    cyc(1);
  endtask

  initial begin
    #(PERIOD * 150000);
    errs++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end

  initial begin
    bit ok;
    int r;
    cyc(3);
    // R1 reset state
    chk(ir == 1'b1, "R1 ir during reset", ir, 1);
    chk(orr == 1'b0, "R1 or during reset", orr, 0);
    rstN = 1'b1;
    cyc(3);
    chk(ir == 1'b1 && orr == 1'b0, "R1 after release", {ir, orr}, 2);

    // R4 fall-through
    push(4'hA, 1'b1);
    cyc(3);
    chk(orr == 1'b1, "R4 or after first write", orr, 1);
    chk(dout == 4'hA, "R4 word falls through", dout, 4'hA);

    // Fill to DEPTH, sweep pattern (R3 full)
    for (int i = 1; i < D; i++) push(W'((i * 5 + 3) % 16), 1'b1);
    cyc(6);
    chk(ir == 1'b0, "R3 ir stays low when full", ir, 0);

    // R2 strobe while full is ignored
    din = 4'hF;
    si = 1'b1;
    cyc(6);
    si = 1'b0;
    cyc(6);
    chk(ir == 1'b0, "R2 ignored strobe keeps full", ir, 0);

    // Drain and check order (R6), then R7 retention
    for (int i = 0; i < D; i++) pop();
    cyc(10);
    chk(orr == 1'b0, "R2 R7 no extra word after drain", orr, 0);
    chk(dout == lastOut, "R7 last word kept", dout, lastOut);
    chk(ir == 1'b1, "R3 ir high when empty", ir, 1);

    // R8 held shift-in against a full buffer
    for (int i = 0; i < D; i++) push(W'(15 - i), 1'b0);
    din = 4'h6;
    si = 1'b1;
    cyc(6);
    chk(ir == 1'b0, "R8 no write while full", ir, 0);
    pop();
    model.push_back(4'h6);
    cyc(10);
    si = 1'b0;
    cyc(6);
    chk(ir == 1'b0, "R8 full again after held write", ir, 0);
    for (int i = 0; i < D; i++) pop();
    cyc(6);
    chk(orr == 1'b0 && dout == 4'h6, "R8 held word last out", dout, 4'h6);

    // R9 held shift-out against an empty buffer
    so = 1'b1;
    cyc(4);
    r = orRises;
    push(4'h9, 1'b0);
    cyc(8);
    chk(orRises == r + 1, "R9 or pulses once", orRises - r, 1);
    chk(orr == 1'b0, "R9 or low while so held", orr, 0);
    chk(dout == 4'h9, "R9 word presented", dout, 4'h9);
    so = 1'b0;
    void'(model.pop_front());
    cyc(8);
    chk(orr == 1'b0 && dout == 4'h9, "R9 R7 empty keeps word", dout, 4'h9);

    // R10 output enable
    oe = 1'b0;
    cyc(1);
    chk(dout === {W{1'bz}}, "R10 high impedance", 0, 0);
    oe = 1'b1;
    cyc(1);
    chk(dout == 4'h9, "R10 drives when enabled", dout, 4'h9);

    // R11 overlapping writes and reads
    for (int i = 0; i < 3; i++) push(W'(i + 1), 1'b0);
    fork
      begin
        for (int i = 0; i < 16; i++) push(W'((i * 7) % 16), 1'b0);
      end
      begin
        for (int i = 0; i < 19; i++) pop();
      end
    join
    cyc(10);
    chk(orr == 1'b0 && model.size() == 0, "R11 all words out in order", model.size(), 0);

    // R1 reset recovery with data stored
    for (int i = 0; i < 3; i++) push(W'(i + 8), 1'b0);
    rstN = 1'b0;
    cyc(2);
    rstN = 1'b1;
    model.delete();
    cyc(3);
    chk(ir == 1'b1 && orr == 1'b0, "R1 reset clears stored words", {ir, orr}, 2);
    push(4'h5, 1'b1);
    pop();
    cyc(6);
    chk(orr == 1'b0, "R1 only new word after reset", orr, 0);

    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end
endmodule